// File: doc/BRIEF.md
# Exception Acceptance and Event Coding

This block sits beside the decode stage of an in-order pipeline that has delayed branches. On every decoded instruction it receives the pending exception requests and decides at which instruction boundary the winning request is taken. A request can be taken at once, held until a delay slot has finished, or dropped because the branch will be executed again. When a request is taken, the block emits a one-cycle accept pulse. It also loads a 12-bit event code, zero-extended to the register width, and, for a trap, loads the trap immediate into a separate register.

Each of the eleven general events arrives on its own bit of the request vector. A second vector tags each request as re-execution type (the instruction is run again after the handler) or completion type (the instruction finishes before the handler runs). An unconditional delayed branch always has a delay slot. A conditional delayed branch has one only when it is taken. Two reset requests bypass all boundary rules.

Top module: `exc_accept`

## Requirements
- R1: After hardware reset, `acc_o` and `acc_slot_o` are 0, and `evt_code_o` and `tra_o` are all zeros.
- R2: A request on `por_req` or `mrst_req` in any cycle gives an accept pulse after the next clock edge with code 0x000 (power-on, which wins over manual) or 0x020 (manual). It discards any open delay slot and any held exception.
- R3: A winning request on a valid instruction that is neither a slot-opening branch with a completion-type winner nor a delay slot is accepted after the next clock edge, with `acc_slot_o` = 0.
- R4: The request bit gives the code: bit0 TLB miss read 0x040, bit1 protection read 0x0A0, bit2 address error read 0x0E0, bit3 illegal instruction 0x180, bit4 illegal slot instruction 0x1A0, bit5 trap 0x160, bit6 user breakpoint 0x1E0, bit7 TLB miss write 0x060, bit8 initial page write 0x080, bit9 protection write 0x0C0, bit10 address error write 0x100. Bits 31..12 of `evt_code_o` are zero.
- R5: When several request bits are set, the lowest-numbered bit wins, and its `ev_cpl` bit gives the type (1 = completion).
- R6: A re-execution winner on a slot-opening branch is accepted at once, and no delay slot follows it.
- R7: A completion winner on a slot-opening branch produces no accept on that cycle. It is held and then accepted, with `acc_slot_o` = 0, after the next valid instruction (the slot).
- R8: A re-execution winner in a delay slot is accepted with `acc_slot_o` = 1, and a completion exception held from the branch is discarded.
- R9: A completion winner in a delay slot is accepted after the slot with `acc_slot_o` = 1, unless a held branch exception exists. In that case the held one is accepted with `acc_slot_o` = 0.
- R10: A conditional delayed branch with `id_taken` = 0 opens no slot. Its exceptions, and those of the next instruction, follow R3.
- R11: When a trap (bit5) is accepted, `tra_o` is loaded with the immediate of the trapping instruction, including when the acceptance was deferred. Otherwise `tra_o` holds.
- R12: `acc_o` is high for one cycle per acceptance, and `evt_code_o` holds its value until the next acceptance.
- R13: In cycles with `id_valid` = 0 and no reset request, requests are ignored and an open delay slot stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| por_req | input | 1 | Power-on reset request |
| mrst_req | input | 1 | Manual reset request |
| id_valid | input | 1 | A decoded instruction is present this cycle |
| id_dbr | input | 1 | Instruction is a delayed branch |
| id_cond | input | 1 | Delayed branch is conditional |
| id_taken | input | 1 | Conditional branch condition is true |
| ev_req | input | 11 | Exception request per event |
| ev_cpl | input | 11 | Type per event: 1 completion, 0 re-execution |
| trap_imm | input | IMM_W | Trap immediate of the instruction |
| acc_o | output | 1 | Exception accepted pulse |
| acc_slot_o | output | 1 | Accepted exception refers to the delay slot instruction |
| evt_code_o | output | REG_W | Event code register, bits 11..0 used |
| tra_o | output | IMM_W | Trap immediate register |

## Verification
The bench builds the block with its default parameters: a 32-bit event register and an 8-bit trap immediate. These widths make the zero upper field of the code register visible, and let full-range immediates be used to show which instruction's immediate is captured. With these settings, every boundary case can be reached by walking short instruction sequences:
- deferral across a slot,
- a slot re-execution cancelling a held branch event,
- a held event competing with a slot event,
- stalls inside a slot,
- resets cutting a slot short.

// File: rtl/exc_accept.sv
module exc_accept #(
  parameter int REG_W = 32,
  parameter int IMM_W = 8,
  localparam int NEV  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_req,
  input  logic             mrst_req,
  input  logic             id_valid,
  input  logic             id_dbr,
  input  logic             id_cond,
  input  logic             id_taken,
  input  logic [NEV-1:0]   ev_req,
  input  logic [NEV-1:0]   ev_cpl,
  input  logic [IMM_W-1:0] trap_imm,
  output logic             acc_o,
  output logic             acc_slot_o,
  output logic [REG_W-1:0] evt_code_o,
  output logic [IMM_W-1:0] tra_o
);
  localparam int CW = 12;
  localparam int IW = $clog2(NEV);
  localparam logic [IW-1:0] TRAP_IDX = IW'(5);
  localparam logic [CW-1:0] CODE_POR  = 12'h000;
  localparam logic [CW-1:0] CODE_MRST = 12'h020;

  function automatic logic [CW-1:0] code_of(input logic [IW-1:0] i);
    case (i)
      4'd0:    code_of = 12'h040;
      4'd1:    code_of = 12'h0A0;
      4'd2:    code_of = 12'h0E0;
      4'd3:    code_of = 12'h180;
      4'd4:    code_of = 12'h1A0;
      4'd5:    code_of = 12'h160;
      4'd6:    code_of = 12'h1E0;
      4'd7:    code_of = 12'h060;
      4'd8:    code_of = 12'h080;
      4'd9:    code_of = 12'h0C0;
      4'd10:   code_of = 12'h100;
      default: code_of = 12'h000;
    endcase
  endfunction

  logic [IW-1:0]    win;
  logic             any, win_cpl, has_slot;
  logic             in_slot, pend_v, pend_trap;
  logic [CW-1:0]    pend_code, code_q;
  logic [IMM_W-1:0] pend_imm;
  logic             take, take_slot, take_trap;
  logic [CW-1:0]    take_code;
  logic [IMM_W-1:0] take_imm;

  always_comb begin
    win = '0;
    for (int i = NEV-1; i >= 0; i--)
      if (ev_req[i]) win = IW'(i);
  end

  assign any      = |ev_req;
  assign win_cpl  = ev_cpl[win];
  assign has_slot = id_dbr & (~id_cond | id_taken);

  always_comb begin
    take      = 1'b0;
    take_slot = 1'b0;
    take_code = code_of(win);
    take_trap = (win == TRAP_IDX);
    take_imm  = trap_imm;
    if (id_valid) begin
      if (!in_slot) begin
        take = any && !(has_slot && win_cpl);
      end else if (any && !win_cpl) begin
        take      = 1'b1;
        take_slot = 1'b1;
      end else if (pend_v) begin
        take      = 1'b1;
        take_code = pend_code;
        take_trap = pend_trap;
        take_imm  = pend_imm;
      end else if (any) begin
        take      = 1'b1;
        take_slot = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o      <= 1'b0;
      acc_slot_o <= 1'b0;
      code_q     <= '0;
      tra_o      <= '0;
      in_slot    <= 1'b0;
      pend_v     <= 1'b0;
      pend_trap  <= 1'b0;
      pend_code  <= '0;
      pend_imm   <= '0;
    end else begin
      acc_o      <= 1'b0;
      acc_slot_o <= 1'b0;
      if (por_req || mrst_req) begin
        acc_o   <= 1'b1;
        code_q  <= por_req ? CODE_POR : CODE_MRST;
        in_slot <= 1'b0;
        pend_v  <= 1'b0;
      end else if (id_valid) begin
        if (take) begin
          acc_o      <= 1'b1;
          acc_slot_o <= take_slot;
          code_q     <= take_code;
          if (take_trap) tra_o <= take_imm;
        end
        if (in_slot) begin
          in_slot <= 1'b0;
          pend_v  <= 1'b0;
        end else if (any && has_slot && win_cpl) begin
          in_slot   <= 1'b1;
          pend_v    <= 1'b1;
          pend_code <= code_of(win);
          pend_trap <= (win == TRAP_IDX);
          pend_imm  <= trap_imm;
        end else begin
          in_slot <= has_slot && !any;
        end
      end
    end
  end

  assign evt_code_o = {{(REG_W-CW){1'b0}}, code_q};
endmodule

module exc_accept_chk #(
  parameter int REG_W = 32,
  parameter int IMM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_req,
  input logic             mrst_req,
  input logic             id_valid,
  input logic             id_dbr,
  input logic             id_cond,
  input logic             id_taken,
  input logic [10:0]      ev_req,
  input logic [10:0]      ev_cpl,
  input logic             in_slot,
  input logic             acc_o,
  input logic [REG_W-1:0] evt_code_o,
  input logic [IMM_W-1:0] tra_o
);
  AST_POR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    por_req |=> acc_o && evt_code_o == '0); // R2
  AST_MRST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    mrst_req && !por_req |=> acc_o && evt_code_o == REG_W'(12'h020)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid && !por_req && !mrst_req |=> !acc_o); // R13
  AST_BRANCH_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && !por_req && !mrst_req && !in_slot && id_dbr && (!id_cond || id_taken)
    && ev_req != '0 && (ev_req & ~ev_cpl) == '0 |=> !acc_o); // R7
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_o |-> $stable(evt_code_o)); // R12
  AST_TRA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_o |-> $stable(tra_o)); // R11
endmodule

bind exc_accept exc_accept_chk #(.REG_W(REG_W), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/tb_exc_accept.sv
`timescale 1ns/1ps
module tb_exc_accept;
  logic clk = 1'b0, rst_n = 1'b0;
  logic por_req = 0, mrst_req = 0, id_valid = 0, id_dbr = 0, id_cond = 0, id_taken = 0;
  logic [10:0] ev_req = '0, ev_cpl = '0;
  logic [7:0]  trap_imm = '0;
  logic        acc_o, acc_slot_o;
  logic [31:0] evt_code_o;
  logic [7:0]  tra_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  exc_accept dut (.*);

  localparam logic [10:0] TLBR = 11'h001, PRTR = 11'h002, ADRR = 11'h004, ILL = 11'h008,
                          TRAP = 11'h020, BRK  = 11'h040, TLBW = 11'h080, IPW = 11'h100,
                          PRTW = 11'h200, ADRW = 11'h400;

  function automatic logic [49:0] V(bit p, bit m, bit v, bit d, bit c, bit t,
      logic [10:0] rq, logic [10:0] cp, logic [7:0] im, bit ea, bit es, logic [11:0] ec);
    return {p, m, v, d, c, t, rq, cp, im, ea, es, ec};
  endfunction

  localparam int NV = 25;
  localparam logic [49:0] VEC [NV] = '{
    V(0,0,1,0,0,0, 0,         0,    0, 0,0,12'h000), // R3 no request
    V(0,0,1,0,0,0, ILL,       0,    0, 1,0,12'h180), // R3 R4
    V(0,0,1,0,0,0, BRK|TLBW,  BRK,  0, 1,0,12'h1E0), // R5
    V(0,0,1,0,0,0, ADRW,      ADRW, 0, 1,0,12'h100), // R4
    V(0,0,0,0,0,0, TLBR,      0,    0, 0,0,12'h100), // R13 R12
    V(0,0,1,1,0,0, TLBR,      0,    0, 1,0,12'h040), // R6
    V(0,0,1,0,0,0, IPW,       IPW,  0, 1,0,12'h080), // R6 no slot
    V(0,0,1,1,0,0, BRK,       BRK,  0, 0,0,12'h080), // R7 defer
    V(0,0,0,0,0,0, ADRR,      0,    0, 0,0,12'h080), // R13 stall in slot
    V(0,0,1,0,0,0, 0,         0,    0, 1,0,12'h1E0), // R7 release
    V(0,0,1,1,1,1, TRAP,      TRAP, 8'h5A, 0,0,12'h1E0), // R7
    V(0,0,1,0,0,0, PRTW,      0,    0, 1,1,12'h0C0), // R8
    V(0,0,1,0,0,0, 0,         0,    0, 0,0,12'h0C0), // R8 held dropped
    V(0,0,1,1,0,0, 0,         0,    0, 0,0,12'h0C0),
    V(0,0,1,0,0,0, ADRR,      ADRR, 0, 1,1,12'h0E0), // R9
    V(0,0,1,1,0,0, PRTR,      PRTR, 0, 0,0,12'h0E0),
    V(0,0,1,0,0,0, IPW,       IPW,  0, 1,0,12'h0A0), // R9 held wins
    V(0,0,1,0,0,0, 0,         0,    0, 0,0,12'h0A0),
    V(0,0,1,1,1,0, TLBW,      TLBW, 0, 1,0,12'h060), // R10
    V(0,0,1,1,1,0, 0,         0,    0, 0,0,12'h060), // R10
    V(0,0,1,0,0,0, ILL,       0,    0, 1,0,12'h180), // R10 not a slot
    V(0,0,1,1,0,0, BRK,       BRK,  0, 0,0,12'h180),
    V(0,1,1,0,0,0, ILL,       0,    0, 1,0,12'h020), // R2
    V(0,0,1,0,0,0, 0,         0,    0, 0,0,12'h020), // R2 held cleared
    V(1,1,1,0,0,0, TLBR,      0,    0, 1,0,12'h000)  // R2 priority
  };

  task automatic chk(string r, logic ea, logic es, logic [11:0] ec);
    n_chk++;
    if (acc_o !== ea || acc_slot_o !== es || evt_code_o !== {20'h0, ec}) begin
      n_fail++;
      $display("FAIL %s: acc/slot/code = %0b/%0b/%h expected %0b/%0b/%h",
               r, acc_o, acc_slot_o, evt_code_o, ea, es, {20'h0, ec});
    end
  endtask

  task automatic chk_tra(string r, logic [7:0] e);
    n_chk++;
    if (tra_o !== e) begin
      n_fail++;
      $display("FAIL %s: tra = %h expected %h", r, tra_o, e);
    end
  endtask

  task automatic step(bit v, bit d, logic [10:0] rq, logic [10:0] cp, logic [7:0] im);
    @(negedge clk);
    {por_req, mrst_req, id_valid, id_dbr, id_cond, id_taken} = {2'b00, v, d, 2'b00};
    ev_req = rq; ev_cpl = cp; trap_imm = im;
    @(posedge clk); #1;
  endtask

  initial begin
    #10000000;
    n_fail++;
    $display("FAIL watchdog: timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 0, 0, 12'h000);
    chk_tra("R1", 8'h00);
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      {por_req, mrst_req, id_valid, id_dbr, id_cond, id_taken,
       ev_req, ev_cpl, trap_imm} = VEC[k][49:14];
      @(posedge clk); #1;
      chk($sformatf("vector %0d (R2..R13)", k), VEC[k][13], VEC[k][12], VEC[k][11:0]);
    end
    chk_tra("R11 dropped trap not loaded", 8'h00);
    step(1, 0, TRAP, TRAP, 8'hC3);
    chk("R11", 1, 0, 12'h160);
    chk_tra("R11", 8'hC3);
    step(1, 1, TRAP, TRAP, 8'h3C);
    chk("R11 defer", 0, 0, 12'h160);
    step(1, 0, 0, 0, 8'hFF);
    chk("R11 release", 1, 0, 12'h160);
    chk_tra("R11 branch immediate", 8'h3C);
    step(1, 0, ILL, 0, 8'h11);
    chk("R4", 1, 0, 12'h180);
    chk_tra("R11 hold", 8'h3C);
    step(0, 0, 0, 0, 0);
    chk("R12 pulse", 0, 0, 12'h180);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule